// File: doc/BRIEF.md
# Variable Line-Size Read Cache

This block is a small direct-mapped read cache. Software picks how much data is fetched on a miss, and it can change that choice at run time. Storage is organised in 32-byte sublines. Each subline keeps its own tag, a valid flag, its data and the fetch size that was active when it was filled. A lookup compares only the subline that the request selects.

Software writes a 2-bit size setting through a dedicated register port. The setting selects a fill of 1, 2, 4 or 8 sublines (32, 64, 128 or 256 bytes). On a miss, the block asks stacked memory for the naturally aligned group of sublines that contains the requested one. Memory answers with one 32-byte beat per cycle over a wide bus. All addresses are word addresses with 32-bit words: bits [2:0] pick the word, bits [5:3] the subline, the next bits the block, and the top bits form the tag.

Three counters are provided so that a bench can compare fetch volume against the expected value for each size: accepted requests, misses and sublines fetched.

Top module: `vls_cache`

## Requirements
- R1: After reset, all sublines are invalid, so the first read misses. The size setting reads 0, the counters read 0, and `busy`, `rsp_valid` and `mem_req` are low.
- R2: A write on `cfg_we` loads `cfg_size` into `cur_size` at that clock edge. The encoding is 0 = 1 subline (32 B), 1 = 2, 2 = 4 and 3 = 8 sublines (256 B).
- R3: A miss raises `mem_req` for exactly one cycle, in the cycle after the request is accepted. It carries `mem_cnt` = 1 << size and `mem_base` = request subline address (word address >> 3) with its low `size` bits cleared.
- R4: The block takes one beat per cycle while `mem_beat_valid` is high and writes the beats to sublines base, base+1 and so on. In the cycle after the last beat, it pulses `rsp_valid` with `rsp_hit`=0, the requested word, and `rsp_size` equal to the fill size.
- R5: A read whose subline is valid with a matching tag is a hit, whatever size that subline was filled with. In the next cycle it pulses `rsp_valid` with `rsp_hit`=1, the stored word, and the subline's recorded fill size on `rsp_size`.
- R6: A fill validates every subline of its aligned group and leaves the other sublines of the block unchanged.
- R7: A size write changes nothing already cached. It takes effect from the next miss.
- R8: A read of a cached subline position with a different tag misses, and its fill replaces that position.
- R9: `cnt_access` counts accepted requests, `cnt_miss` counts misses, and `cnt_fetched` counts beats taken.
- R10: While `busy` is high, `req_valid` is ignored. It is not counted and gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, taken when not busy |
| req_addr | input | AW | Word address of the read |
| busy | output | 1 | A miss is in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response was a hit |
| rsp_data | output | WORD | Read word |
| rsp_size | output | 2 | Fill size recorded for the read subline |
| cfg_we | input | 1 | Size register write strobe |
| cfg_size | input | 2 | New size setting |
| cur_size | output | 2 | Current size setting |
| mem_req | output | 1 | Fill request pulse |
| mem_base | output | AW-3 | First subline address of the fill |
| mem_cnt | output | 4 | Number of sublines to fetch |
| mem_beat_valid | input | 1 | Memory beat present |
| mem_beat_data | input | 256 | One 32-byte subline |
| cnt_access | output | CW | Accepted request count |
| cnt_miss | output | CW | Miss count |
| cnt_fetched | output | CW | Sublines fetched |

## Verification
A hit response is due one cycle after the accepting edge. The bench drives requests at a falling edge and reads the response at the next falling edge. A miss raises `mem_req` one cycle after acceptance, and the bench reads the base and count in that same half-cycle. The bench then supplies beats one per falling edge and expects the response at the falling edge that follows the last beat. It also checks that the response has dropped one cycle later. Size writes are checked one falling edge after the strobe, and the counters are compared against totals that the bench keeps for itself.

// File: rtl/vls_cache.sv
module vls_cache #(
  parameter int AW   = 14,
  parameter int NBLK = 4,
  parameter int WORD = 32,
  parameter int CW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  output logic                 busy,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [WORD-1:0]      rsp_data,
  output logic [1:0]           rsp_size,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_size,
  output logic [1:0]           cur_size,
  output logic                 mem_req,
  output logic [AW-4:0]        mem_base,
  output logic [3:0]           mem_cnt,
  input  logic                 mem_beat_valid,
  input  logic [255:0]         mem_beat_data,
  output logic [CW-1:0]        cnt_access,
  output logic [CW-1:0]        cnt_miss,
  output logic [CW-1:0]        cnt_fetched
);
  localparam int LINE = 256;
  localparam int WPS  = LINE / WORD;
  localparam int WSW  = $clog2(WPS);
  localparam int SUBW = 3;
  localparam int IDXW = $clog2(NBLK);
  localparam int TAGW = AW - WSW - SUBW - IDXW;
  localparam int ENT  = NBLK * (1 << SUBW);
  localparam int EW   = IDXW + SUBW;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL} st_t;
  st_t st;

  logic [TAGW-1:0] tag_q [ENT];
  logic [1:0]      sz_q  [ENT];
  logic [LINE-1:0] dat_q [ENT];
  logic [ENT-1:0]  val_q;

  wire [WSW-1:0]  a_w   = req_addr[WSW-1:0];
  wire [SUBW-1:0] a_sub = req_addr[WSW +: SUBW];
  wire [IDXW-1:0] a_idx = req_addr[WSW+SUBW +: IDXW];
  wire [TAGW-1:0] a_tag = req_addr[AW-1 -: TAGW];
  wire [EW-1:0]   a_ent = {a_idx, a_sub};
  wire            hit   = val_q[a_ent] && (tag_q[a_ent] == a_tag);
  wire            take  = req_valid && (st == S_IDLE);

  logic [TAGW-1:0] m_tag;
  logic [IDXW-1:0] m_idx;
  logic [SUBW-1:0] m_base, m_sub;
  logic [WSW-1:0]  m_w;
  logic [1:0]      m_size;
  logic [3:0]      beat_k;
  logic [WORD-1:0] fill_word;
  logic [1:0]      size_q;

  wire [3:0]      fill_n   = 4'd1 << m_size;
  wire [SUBW-1:0] beat_sub = m_base + beat_k[SUBW-1:0];
  wire [EW-1:0]   beat_ent = {m_idx, beat_sub};
  wire            beat     = mem_beat_valid && (st == S_FILL);
  wire            last     = beat && (beat_k == fill_n - 4'd1);
  wire [WORD-1:0] beat_word = mem_beat_data[m_w*WORD +: WORD];
  wire [SUBW-1:0] grp_mask = SUBW'((4'd1 << size_q) - 4'd1);

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_REQ);
  assign mem_base = {m_tag, m_idx, m_base};
  assign mem_cnt  = fill_n;
  assign cur_size = size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= 2'd0;
    else if (cfg_we) size_q <= cfg_size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else if (beat) val_q[beat_ent] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (beat) begin
      tag_q[beat_ent] <= m_tag;
      sz_q[beat_ent]  <= m_size;
      dat_q[beat_ent] <= mem_beat_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      m_tag <= '0; m_idx <= '0; m_base <= '0; m_sub <= '0; m_w <= '0; m_size <= '0;
      beat_k <= '0; fill_word <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_data <= '0; rsp_size <= '0;
      cnt_access <= '0; cnt_miss <= '0; cnt_fetched <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          cnt_access <= cnt_access + 1'b1;
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_data  <= dat_q[a_ent][a_w*WORD +: WORD];
            rsp_size  <= sz_q[a_ent];
          end else begin
            cnt_miss <= cnt_miss + 1'b1;
            m_tag  <= a_tag;
            m_idx  <= a_idx;
            m_sub  <= a_sub;
            m_w    <= a_w;
            m_size <= size_q;
            m_base <= a_sub & ~grp_mask;
            beat_k <= '0;
            st     <= S_REQ;
          end
        end
        S_REQ: st <= S_FILL;
        S_FILL: if (beat) begin
          cnt_fetched <= cnt_fetched + 1'b1;
          beat_k <= beat_k + 4'd1;
          if (beat_sub == m_sub) fill_word <= beat_word;
          if (last) begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_data  <= (beat_sub == m_sub) ? beat_word : fill_word;
            rsp_size  <= m_size;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cur_size == $past(cfg_size));
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_req_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_cnt) == 1) &&
                ((mem_base[SUBW-1:0] & (mem_cnt[SUBW-1:0] - 3'd1)) == '0));
  assert_beat_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL) |-> (beat_k < fill_n));
  assert_hit_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(req_valid) && !$past(busy));
  assert_fetch_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> cnt_fetched == $past(cnt_fetched) + 1'b1);
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt_access == $past(cnt_access));
endmodule

// File: tb/vls_cache_tb_top.sv
module vls_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [13:0] req_addr = '0;
  logic busy, rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic [1:0] rsp_size, cur_size;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_size = '0;
  logic mem_req;
  logic [10:0] mem_base;
  logic [3:0] mem_cnt;
  logic mem_beat_valid = 1'b0;
  logic [255:0] mem_beat_data = '0;
  logic [31:0] cnt_access, cnt_miss, cnt_fetched;

  always #5 clk = ~clk;

  vls_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .rsp_size(rsp_size), .cfg_we(cfg_we), .cfg_size(cfg_size), .cur_size(cur_size),
    .mem_req(mem_req), .mem_base(mem_base), .mem_cnt(mem_cnt),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
    .cnt_access(cnt_access), .cnt_miss(cnt_miss), .cnt_fetched(cnt_fetched));

  int checks = 0, errors = 0;
  int exp_acc = 0, exp_miss = 0, exp_fetch = 0;
  logic [7:0] epoch = 8'd0;
  logic [1:0] cur_sz = 2'd0;
  logic [7:0] shadow_ep [32];
  logic [1:0] shadow_sz [32];
  bit done = 1'b0;

  function automatic logic [31:0] mword(input logic [10:0] sa, input logic [2:0] w, input logic [7:0] ep);
    return {ep, 5'd0, sa, 5'd0, w};
  endfunction

  task automatic eq(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic setsz(input logic [1:0] s);
    @(negedge clk); cfg_we = 1'b1; cfg_size = s;
    @(negedge clk); cfg_we = 1'b0;
    cur_sz = s;
    eq("R2", "cur_size after write", 64'(cur_size), 64'(s));
  endtask

  task automatic rd(input logic [13:0] a, input bit exp_hit, input bit poke, input string rq);
    int e;
    int n;
    logic [10:0] base;
    e = int'(a[7:6]) * 8 + int'(a[5:3]);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    exp_acc++;
    if (exp_hit) begin
      eq(rq, "hit rsp_valid", 64'(rsp_valid), 64'd1);
      eq(rq, "hit flag", 64'(rsp_hit), 64'd1);
      eq(rq, "hit data", 64'(rsp_data), 64'(mword(a[13:3], a[2:0], shadow_ep[e])));
      eq(rq, "hit size", 64'(rsp_size), 64'(shadow_sz[e]));
      eq(rq, "no mem_req on hit", 64'(mem_req), 64'd0);
    end else begin
      n = 1 << cur_sz;
      base = a[13:3] & ~11'(n - 1);
      exp_miss++;
      epoch = epoch + 8'd1;
      eq(rq, "miss no early rsp", 64'(rsp_valid), 64'd0);
      eq("R3", "mem_req raised", 64'(mem_req), 64'd1);
      eq("R3", "mem_base", 64'(mem_base), 64'(base));
      eq("R3", "mem_cnt", 64'(mem_cnt), 64'(n));
      @(negedge clk);
      eq("R3", "mem_req one cycle", 64'(mem_req), 64'd0);
      if (poke) begin
        req_valid = 1'b1; req_addr = a ^ 14'h100;
        @(negedge clk); req_valid = 1'b0;
        eq("R10", "busy during fill", 64'(busy), 64'd1);
        eq("R10", "no rsp to ignored read", 64'(rsp_valid), 64'd0);
      end
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
        mem_beat_valid = 1'b1;
        for (int w = 0; w < 8; w++)
          mem_beat_data[w*32 +: 32] = mword(base + 11'(k), 3'(w), epoch);
        @(negedge clk);
        exp_fetch++;
        shadow_ep[int'(a[7:6]) * 8 + int'(base[2:0]) + k] = epoch;
        shadow_sz[int'(a[7:6]) * 8 + int'(base[2:0]) + k] = cur_sz;
      end
      mem_beat_valid = 1'b0;
      eq("R4", "fill rsp_valid", 64'(rsp_valid), 64'd1);
      eq("R4", "fill rsp_hit low", 64'(rsp_hit), 64'd0);
      eq("R4", "fill data", 64'(rsp_data), 64'(mword(a[13:3], a[2:0], epoch)));
      eq("R4", "fill size", 64'(rsp_size), 64'(cur_sz));
      @(negedge clk);
      eq("R4", "rsp is a pulse", 64'(rsp_valid), 64'd0);
      eq("R4", "idle after fill", 64'(busy), 64'd0);
    end
  endtask

  task automatic t_reset;
    eq("R1", "cur_size", 64'(cur_size), 64'd0);
    eq("R1", "busy", 64'(busy), 64'd0);
    eq("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    eq("R1", "mem_req", 64'(mem_req), 64'd0);
    eq("R1", "counters", 64'(cnt_access | cnt_miss | cnt_fetched), 64'd0);
  endtask

  task automatic t_counters(input string tag);
    eq("R9", {tag, " access"}, 64'(cnt_access), 64'(exp_acc));
    eq("R9", {tag, " miss"}, 64'(cnt_miss), 64'(exp_miss));
    eq("R9", {tag, " fetched"}, 64'(cnt_fetched), 64'(exp_fetch));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rd(14'h010, 1'b0, 1'b0, "R1");
    rd(14'h011, 1'b1, 1'b0, "R5");
    rd(14'h008, 1'b0, 1'b0, "R6");
    setsz(2'd1);
    rd(14'h059, 1'b0, 1'b0, "R3");
    rd(14'h050, 1'b1, 1'b0, "R6");
    setsz(2'd3);
    rd(14'h0BA, 1'b0, 1'b0, "R3");
    rd(14'h080, 1'b1, 1'b0, "R6");
    rd(14'h0BF, 1'b1, 1'b0, "R6");
    t_counters("mid");
    setsz(2'd2);
    rd(14'h32B, 1'b0, 1'b0, "R8");
    rd(14'h010, 1'b1, 1'b0, "R6");
    rd(14'h008, 1'b1, 1'b0, "R6");
    rd(14'h320, 1'b1, 1'b0, "R5");
    rd(14'h020, 1'b0, 1'b0, "R8");
    rd(14'h32B, 1'b0, 1'b0, "R8");
    setsz(2'd0);
    rd(14'h0BA, 1'b1, 1'b0, "R7");
    rd(14'h0C0, 1'b0, 1'b1, "R10");
    rd(14'h0C8, 1'b0, 1'b0, "R7");
    rd(14'h0C1, 1'b1, 1'b0, "R5");
    t_counters("end");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule